// File: doc/BRIEF.md
# Waveform Timer Counter Core

This block is one timer channel that generates waveform timing events. It chooses a counting clock from a free-running system-rate source, three divided internal clocks, a slow clock input or one of three external inputs. It can count on the opposite edge of that clock and can gate it with one of the external inputs. All clocks are treated as levels sampled in the system clock domain, and the counter moves only on a one-cycle tick taken from the chosen edge. The whole block is therefore synchronous to `clk`.

The counter runs up, or up then down, and is compared against three values A, B and C. It can reset itself automatically when it reaches C. Reaching C can also halt counting until the next trigger, or switch counting off until a new enable strobe. A software strobe or a qualified external edge triggers the counter: it clears the count and starts counting. The block emits one-cycle strobes for each compare match, for every trigger, and for every qualified external edge. Output shaping logic downstream uses these strobes.

The control word is written through `cfg_wr_i`/`cfg_data_i`. Its fields are, by bit: [1:0] counting mode, [4:2] clock select, [5] clock invert, [7:6] gate select, [8] halt-on-C, [9] switch-off-on-C, [11:10] event source, [13:12] event edge, [14] event trigger enable.

Top module: `wavegen_timer`

## Requirements
- R1: Mode 0 counts up by one per tick with no automatic trigger, and wraps from all ones to zero.
- R2: Mode 2 counts up, and on the tick after the count has reached C it returns to zero and pulses `trig_o` for one cycle.
- R3: Modes 1 and 3 count up to a turning value and then down to zero, and turn up again at zero. The turning value is all ones in mode 1 and C in mode 3. No automatic trigger is issued in these modes.
- R4: Clock select 0 is a system-rate source giving one tick every 2 cycles. Selects 1, 2 and 3 give one tick every 8, 32 and 128 cycles. Select 4 ticks on rising edges of `slow_clk_i`, and selects 5 to 7 tick on rising edges of `ext_i[0]` to `ext_i[2]`.
- R5: With the invert bit set, the counter ticks on the falling edge of the selected clock and not on its rising edge.
- R6: Gate select 0 passes the clock unchanged. Gate selects 1 to 3 AND the clock with `ext_i[0]` to `ext_i[2]`, so no tick occurs while that input is low.
- R7: `cmp_a_o`, `cmp_b_o` and `cmp_c_o` each pulse for one cycle when a counting tick moves the count onto A, B or C respectively.
- R8: With halt-on-C set, counting stops with the count held at C. A software or external trigger clears the count and resumes counting.
- R9: With switch-off-on-C set, reaching C switches counting off. A trigger alone then clears the count but does not restart counting, and a `start_i` strobe followed by a trigger does restart it.
- R10: Event source 0 selects `pin_b_i` and sources 1 to 3 select `ext_i[0]` to `ext_i[2]`. Event edge 0 means none, 1 rising, 2 falling and 3 both edges. Every qualified edge pulses `ext_evt_o` for one cycle.
- R11: With event trigger enable set, a qualified event clears the count, pulses `trig_o` and starts counting. With it clear, the count is unaffected.
- R12: A control word write is ignored while `wp_en_i` is high.
- R13: After reset the count is zero and counting is off. Counting needs a `start_i` strobe and then a trigger. `stop_i` halts counting, and `start_i` resumes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_i | input | 1 | Control word write strobe |
| cfg_data_i | input | 15 | Control word |
| wp_en_i | input | 1 | Write protect for the control word |
| ra_i | input | CNT_W | Compare value A |
| rb_i | input | CNT_W | Compare value B |
| rc_i | input | CNT_W | Compare value C |
| start_i | input | 1 | Enable counting strobe |
| stop_i | input | 1 | Disable counting strobe |
| swtrig_i | input | 1 | Software trigger strobe |
| slow_clk_i | input | 1 | Slow clock level |
| ext_i | input | 3 | External inputs (clock, gate, event) |
| pin_b_i | input | 1 | B pin used as event input |
| count_o | output | CNT_W | Counter value |
| active_o | output | 1 | Counting is enabled and running |
| trig_o | output | 1 | Trigger strobe |
| cmp_a_o | output | 1 | Compare A strobe |
| cmp_b_o | output | 1 | Compare B strobe |
| cmp_c_o | output | 1 | Compare C strobe |
| ext_evt_o | output | 1 | Qualified external event strobe |

## Verification
Two situations are hard to reach from the ports. The first is the turn at the all-ones value in the up/down mode without automatic trigger. The second is the difference between a halted counter and a switched-off one, because both show a frozen count. The bench builds the block with an 8-bit counter and drives the counting clock itself through an external input, so it controls every tick and can walk the count to its top value in a few hundred cycles. The two halt kinds are then told apart by applying a trigger alone and checking whether counting resumes, before and after a `start_i` strobe.

// File: rtl/wtc_pkg.sv
package wtc_pkg;

   localparam int N_EXT = 3;

   typedef enum logic [1:0] {
      WM_UP       = 2'd0,
      WM_UPDN     = 2'd1,
      WM_UP_AUTO  = 2'd2,
      WM_UPDN_AUTO = 2'd3
   } wave_mode_e;

   typedef enum logic [1:0] {
      EDGE_OFF  = 2'd0,
      EDGE_RISE = 2'd1,
      EDGE_FALL = 2'd2,
      EDGE_ANY  = 2'd3
   } edge_sel_e;

   typedef struct packed {
      logic       trig_en;    // [14]
      edge_sel_e  evt_edge;   // [13:12]
      logic [1:0] evt_src;    // [11:10]
      logic       dis_on_c;   // [9]
      logic       stop_on_c;  // [8]
      logic [1:0] gate_sel;   // [7:6]
      logic       clk_inv;    // [5]
      logic [2:0] clk_sel;    // [4:2]
      wave_mode_e mode;       // [1:0]
   } wtc_cfg_t;

   localparam int CFG_W = $bits(wtc_cfg_t);

endpackage

// File: rtl/wtc_clock_sel.sv
module wtc_clock_sel
   import wtc_pkg::*;
#(
   parameter int DIV_A_LOG = 3,
   parameter int DIV_B_LOG = 5,
   parameter int DIV_C_LOG = 7
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:0]       clk_sel_i,
   input  logic             clk_inv_i,
   input  logic [1:0]       gate_sel_i,
   input  logic             slow_clk_i,
   input  logic [N_EXT-1:0] ext_i,
   output logic             tick_o
);

   localparam int PRE_W   = DIV_C_LOG;
   localparam int N_SRC   = 5 + N_EXT;
   localparam int N_GATE  = 1 + N_EXT;

   generate
      if (DIV_A_LOG < 1 || DIV_B_LOG <= DIV_A_LOG || DIV_C_LOG <= DIV_B_LOG) begin : g_bad_div
         $error("divider exponents must be positive and strictly increasing");
      end
   endgenerate

   logic [PRE_W-1:0]  pre_q;
   logic              fast_q;
   logic [N_SRC-1:0]  src_lvl;
   logic [N_GATE-1:0] gate_lvl;
   logic              lvl, eff, eff_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q  <= '0;
         fast_q <= 1'b0;
      end else begin
         pre_q  <= pre_q + 1'b1;
         fast_q <= ~fast_q;
      end
   end

   assign src_lvl[0] = fast_q;
   assign src_lvl[1] = pre_q[DIV_A_LOG-1];
   assign src_lvl[2] = pre_q[DIV_B_LOG-1];
   assign src_lvl[3] = pre_q[DIV_C_LOG-1];
   assign src_lvl[4] = slow_clk_i;
   assign gate_lvl[0] = 1'b1;

   generate
      for (genvar i = 0; i < N_EXT; i++) begin : g_ext_map
         assign src_lvl[5+i]  = ext_i[i];
         assign gate_lvl[1+i] = ext_i[i];
      end
   endgenerate

   assign lvl = src_lvl[clk_sel_i] & gate_lvl[gate_sel_i];
   assign eff = lvl ^ clk_inv_i;

   // reset high so no tick can appear in the first cycle after reset
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) eff_q <= 1'b1;
      else        eff_q <= eff;
   end

   assign tick_o = eff & ~eff_q;

endmodule

// File: rtl/wtc_event_det.sv
module wtc_event_det
   import wtc_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       evt_src_i,
   input  edge_sel_e        evt_edge_i,
   input  logic             pin_b_i,
   input  logic [N_EXT-1:0] ext_i,
   output logic             evt_o
);

   logic [N_EXT:0] cand;
   logic           sel, prev_q, rise, fall;

   assign cand[0] = pin_b_i;
   generate
      for (genvar i = 0; i < N_EXT; i++) begin : g_cand
         assign cand[1+i] = ext_i[i];
      end
   endgenerate

   assign sel = cand[evt_src_i];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= sel;
   end

   assign rise = sel & ~prev_q;
   assign fall = ~sel & prev_q;

   always_comb begin
      unique case (evt_edge_i)
         EDGE_RISE: evt_o = rise;
         EDGE_FALL: evt_o = fall;
         EDGE_ANY:  evt_o = rise | fall;
         default:   evt_o = 1'b0;
      endcase
   end

endmodule

// File: rtl/wtc_counter.sv
module wtc_counter
   import wtc_pkg::*;
#(
   parameter int CNT_W = 16
)(
   input  logic             clk,
   input  logic             rst_n,
   input  wave_mode_e       mode_i,
   input  logic             stop_on_c_i,
   input  logic             dis_on_c_i,
   input  logic             tick_i,
   input  logic             start_i,
   input  logic             stop_i,
   input  logic             trig_i,
   input  logic [CNT_W-1:0] ra_i,
   input  logic [CNT_W-1:0] rb_i,
   input  logic [CNT_W-1:0] rc_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             active_o,
   output logic             trig_o,
   output logic             cmp_a_o,
   output logic             cmp_b_o,
   output logic             cmp_c_o
);

   generate
      if (CNT_W < 2) begin : g_bad_w
         $error("counter width must be at least 2");
      end
   endgenerate

   localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt_q, cnt_n, top;
   logic             up_q, up_n, wrap_trig, auto_trig, two_way;
   logic             en_q, run_q, step, hit_c;
   logic             trig_q, ca_q, cb_q, cc_q;

   assign auto_trig = mode_i[1];
   assign two_way   = mode_i[0];
   assign top       = auto_trig ? rc_i : ALL_ONES;

   always_comb begin
      cnt_n     = cnt_q + 1'b1;
      up_n      = up_q;
      wrap_trig = 1'b0;
      if (!two_way) begin
         if (auto_trig && cnt_q >= rc_i) begin
            cnt_n     = '0;
            wrap_trig = 1'b1;
         end
      end else if (up_q) begin
         if (cnt_q >= top) begin
            cnt_n = cnt_q - 1'b1;
            up_n  = 1'b0;
         end
      end else begin
         if (cnt_q == '0) up_n  = 1'b1;
         else             cnt_n = cnt_q - 1'b1;
      end
   end

   assign step  = tick_i & en_q & run_q;
   assign hit_c = (cnt_n == rc_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         up_q   <= 1'b1;
         en_q   <= 1'b0;
         run_q  <= 1'b0;
         trig_q <= 1'b0;
         ca_q   <= 1'b0;
         cb_q   <= 1'b0;
         cc_q   <= 1'b0;
      end else begin
         trig_q <= 1'b0;
         ca_q   <= 1'b0;
         cb_q   <= 1'b0;
         cc_q   <= 1'b0;
         if (stop_i)       en_q <= 1'b0;
         else if (start_i) en_q <= 1'b1;
         if (trig_i) begin
            // a trigger clears the count always, but restarts only an enabled clock
            cnt_q  <= '0;
            up_q   <= 1'b1;
            trig_q <= 1'b1;
            run_q  <= en_q;
         end else if (step) begin
            cnt_q  <= cnt_n;
            up_q   <= up_n;
            trig_q <= wrap_trig;
            ca_q   <= (cnt_n == ra_i);
            cb_q   <= (cnt_n == rb_i);
            cc_q   <= hit_c;
            if (hit_c && (stop_on_c_i || dis_on_c_i)) run_q <= 1'b0;
            if (hit_c && dis_on_c_i)                  en_q  <= 1'b0;
         end
      end
   end

   assign cnt_o    = cnt_q;
   assign active_o = en_q & run_q;
   assign trig_o   = trig_q;
   assign cmp_a_o  = ca_q;
   assign cmp_b_o  = cb_q;
   assign cmp_c_o  = cc_q;

endmodule

// File: rtl/wavegen_timer.sv
module wavegen_timer
   import wtc_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int DIV_A_LOG   = 3,
   parameter int DIV_B_LOG   = 5,
   parameter int DIV_C_LOG   = 7,
   parameter int SYNC_STAGES = 0
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_wr_i,
   input  logic [CFG_W-1:0] cfg_data_i,
   input  logic             wp_en_i,
   input  logic [CNT_W-1:0] ra_i,
   input  logic [CNT_W-1:0] rb_i,
   input  logic [CNT_W-1:0] rc_i,
   input  logic             start_i,
   input  logic             stop_i,
   input  logic             swtrig_i,
   input  logic             slow_clk_i,
   input  logic [N_EXT-1:0] ext_i,
   input  logic             pin_b_i,
   output logic [CNT_W-1:0] count_o,
   output logic             active_o,
   output logic             trig_o,
   output logic             cmp_a_o,
   output logic             cmp_b_o,
   output logic             cmp_c_o,
   output logic             ext_evt_o
);

   localparam int IN_W = N_EXT + 2;

   generate
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("SYNC_STAGES must not be negative");
      end
   endgenerate

   wtc_cfg_t         cfg_q;
   logic [IN_W-1:0]  raw_in, syn_in;
   logic [N_EXT-1:0] ext_s;
   logic             slow_s, pin_b_s;
   logic             tick, evt, trig, evt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    cfg_q <= '0;
      else if (cfg_wr_i && !wp_en_i) cfg_q <= wtc_cfg_t'(cfg_data_i);
   end

   assign raw_in = {pin_b_i, slow_clk_i, ext_i};

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign syn_in = raw_in;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0][IN_W-1:0] st_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               st_q <= '0;
            end else begin
               st_q[0] <= raw_in;
               for (int s = 1; s < SYNC_STAGES; s++) st_q[s] <= st_q[s-1];
            end
         end
         assign syn_in = st_q[SYNC_STAGES-1];
      end
   endgenerate

   assign ext_s   = syn_in[N_EXT-1:0];
   assign slow_s  = syn_in[N_EXT];
   assign pin_b_s = syn_in[N_EXT+1];

   wtc_clock_sel #(
      .DIV_A_LOG (DIV_A_LOG),
      .DIV_B_LOG (DIV_B_LOG),
      .DIV_C_LOG (DIV_C_LOG)
   ) u_clk (
      .clk        (clk),
      .rst_n      (rst_n),
      .clk_sel_i  (cfg_q.clk_sel),
      .clk_inv_i  (cfg_q.clk_inv),
      .gate_sel_i (cfg_q.gate_sel),
      .slow_clk_i (slow_s),
      .ext_i      (ext_s),
      .tick_o     (tick)
   );

   wtc_event_det u_evt (
      .clk        (clk),
      .rst_n      (rst_n),
      .evt_src_i  (cfg_q.evt_src),
      .evt_edge_i (cfg_q.evt_edge),
      .pin_b_i    (pin_b_s),
      .ext_i      (ext_s),
      .evt_o      (evt)
   );

   assign trig = swtrig_i | (evt & cfg_q.trig_en);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) evt_q <= 1'b0;
      else        evt_q <= evt;
   end
   assign ext_evt_o = evt_q;

   wtc_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk         (clk),
      .rst_n       (rst_n),
      .mode_i      (cfg_q.mode),
      .stop_on_c_i (cfg_q.stop_on_c),
      .dis_on_c_i  (cfg_q.dis_on_c),
      .tick_i      (tick),
      .start_i     (start_i),
      .stop_i      (stop_i),
      .trig_i      (trig),
      .ra_i        (ra_i),
      .rb_i        (rb_i),
      .rc_i        (rc_i),
      .cnt_o       (count_o),
      .active_o    (active_o),
      .trig_o      (trig_o),
      .cmp_a_o     (cmp_a_o),
      .cmp_b_o     (cmp_b_o),
      .cmp_c_o     (cmp_c_o)
   );

endmodule

// File: rtl/wtc_checker.sv
module wtc_checker #(
   parameter int CNT_W = 16
)(
   input logic             clk,
   input logic             rst_n,
   input logic [CNT_W-1:0] count_o,
   input logic [CNT_W-1:0] ra_i,
   input logic [CNT_W-1:0] rb_i,
   input logic [CNT_W-1:0] rc_i,
   input logic             active_o,
   input logic             trig_o,
   input logic             cmp_a_o,
   input logic             cmp_b_o,
   input logic             cmp_c_o,
   input logic             stop_cfg,
   input logic             dis_cfg
);

   // R7
   cmp_a_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_a_o |-> count_o == $past(ra_i));

   // R7
   cmp_b_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_b_o |-> count_o == $past(rb_i));

   // R7
   cmp_c_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_c_o |-> count_o == $past(rc_i));

   // R2
   trig_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trig_o |-> count_o == '0);

   // R13
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!trig_o && !$past(active_o)) |-> $stable(count_o));

   // R3
   unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!trig_o && count_o != $past(count_o)) |->
         (CNT_W'(count_o - $past(count_o)) == CNT_W'(1) ||
          CNT_W'($past(count_o) - count_o) == CNT_W'(1)));

   // R8
   halt_on_c_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_c_o && $past(stop_cfg)) |-> !active_o);

   // R9
   off_on_c_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_c_o && $past(dis_cfg)) |-> !active_o);

endmodule

bind wavegen_timer wtc_checker #(.CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .count_o  (count_o),
   .ra_i     (ra_i),
   .rb_i     (rb_i),
   .rc_i     (rc_i),
   .active_o (active_o),
   .trig_o   (trig_o),
   .cmp_a_o  (cmp_a_o),
   .cmp_b_o  (cmp_b_o),
   .cmp_c_o  (cmp_c_o),
   .stop_cfg (cfg_q.stop_on_c),
   .dis_cfg  (cfg_q.dis_on_c)
);

// File: tb/wavegen_timer_test.sv
module wavegen_timer_test;
   import wtc_pkg::*;

   localparam int W = 8;

   logic clk = 0, rst_n = 0;
   logic cfg_wr = 0, wp = 0, start = 0, stop = 0, sw = 0, slow = 0, pinb = 0;
   logic [CFG_W-1:0] cfg_d = '0;
   logic [W-1:0] ra = 8'd3, rb = 8'd5, rc = 8'd6;
   logic [2:0] ext = '0;
   logic [W-1:0] count;
   logic active, trig, ca, cb, cc, evt;

   int n_chk = 0, n_fail = 0;
   int n_a = 0, n_b = 0, n_c = 0, n_t = 0, n_e = 0;
   bit done = 0;

   always #10 clk = ~clk;

   wavegen_timer #(.CNT_W(W)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_wr_i(cfg_wr), .cfg_data_i(cfg_d),
      .wp_en_i(wp), .ra_i(ra), .rb_i(rb), .rc_i(rc), .start_i(start),
      .stop_i(stop), .swtrig_i(sw), .slow_clk_i(slow), .ext_i(ext),
      .pin_b_i(pinb), .count_o(count), .active_o(active), .trig_o(trig),
      .cmp_a_o(ca), .cmp_b_o(cb), .cmp_c_o(cc), .ext_evt_o(evt)
   );

   always @(negedge clk) begin
      if (rst_n) begin
         if (ca)   n_a++;
         if (cb)   n_b++;
         if (cc)   n_c++;
         if (trig) n_t++;
         if (evt)  n_e++;
      end
   end

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic clr();
      n_a = 0; n_b = 0; n_c = 0; n_t = 0; n_e = 0;
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic wtc_cfg_t mk(input int mode, input int sel, input int inv,
                                   input int gate, input int stc, input int dsc,
                                   input int src, input int edg, input int ten);
      wtc_cfg_t c;
      c = '0;
      c.mode      = wave_mode_e'(mode[1:0]);
      c.clk_sel   = sel[2:0];
      c.clk_inv   = inv[0];
      c.gate_sel  = gate[1:0];
      c.stop_on_c = stc[0];
      c.dis_on_c  = dsc[0];
      c.evt_src   = src[1:0];
      c.evt_edge  = edge_sel_e'(edg[1:0]);
      c.trig_en   = ten[0];
      return c;
   endfunction

   task automatic wr_cfg(input wtc_cfg_t c);
      @(negedge clk); cfg_d = c; cfg_wr = 1;
      @(negedge clk); cfg_wr = 0;
   endtask

   task automatic do_sw();
      @(negedge clk); sw = 1; @(negedge clk); sw = 0; @(negedge clk);
   endtask

   task automatic do_start();
      @(negedge clk); start = 1; @(negedge clk); start = 0; @(negedge clk);
   endtask

   task automatic do_stop();
      @(negedge clk); stop = 1; @(negedge clk); stop = 0; @(negedge clk);
   endtask

   task automatic tick0(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk); ext[0] = 1;
         @(negedge clk); ext[0] = 0;
      end
      cyc(2);
   endtask

   task automatic t_reset();
      chk("R13", "count after reset", count, 0);
      chk("R13", "active after reset", active, 0);
      chk("R13", "strobes after reset", {trig, ca, cb, cc, evt}, 0);
      wr_cfg(mk(0, 5, 0, 0, 0, 0, 0, 0, 0));
      tick0(3);
      chk("R13", "no count before start", count, 0);
      do_sw();
      tick0(2);
      chk("R13", "trigger without start", count, 0);
      do_start(); do_sw();
      chk("R13", "active after start+trigger", active, 1);
   endtask

   task automatic t_up();
      wr_cfg(mk(0, 5, 0, 0, 0, 0, 0, 0, 0));
      do_sw(); clr();
      tick0(7);
      chk("R1", "up count", count, 7);
      chk("R7", "cmp A pulses", n_a, 1);
      chk("R7", "cmp B pulses", n_b, 1);
      chk("R7", "cmp C pulses", n_c, 1);
      tick0(249);
      chk("R1", "wrap to zero", count, 0);
      chk("R1", "no auto trigger", n_t, 0);
   endtask

   task automatic t_auto();
      wr_cfg(mk(2, 5, 0, 0, 0, 0, 0, 0, 0));
      do_sw(); clr();
      tick0(6);
      chk("R2", "reach C", count, 6);
      tick0(1);
      chk("R2", "reset after C", count, 0);
      chk("R2", "auto trigger pulses", n_t, 1);
      tick0(3);
      chk("R2", "count after restart", count, 3);
   endtask

   task automatic t_updn();
      wr_cfg(mk(1, 5, 0, 0, 0, 0, 0, 0, 0));
      do_sw();
      tick0(255);
      chk("R3", "reach all ones", count, 255);
      tick0(2);
      chk("R3", "turn at all ones", count, 253);
      wr_cfg(mk(3, 5, 0, 0, 0, 0, 0, 0, 0));
      do_sw(); clr();
      tick0(8);
      chk("R3", "turn at C", count, 4);
      chk("R3", "cmp C once", n_c, 1);
      chk("R3", "no trigger in up/down", n_t, 0);
      tick0(6);
      chk("R3", "turn at zero", count, 2);
   endtask

   task automatic t_clk_sel();
      int c0;
      wr_cfg(mk(0, 0, 0, 0, 0, 0, 0, 0, 0));
      do_sw(); cyc(3); c0 = count; cyc(16);
      chk("R4", "sel 0 ticks in 16", int'(W'(count - c0)), 8);
      wr_cfg(mk(0, 1, 0, 0, 0, 0, 0, 0, 0));
      do_sw(); cyc(3); c0 = count; cyc(64);
      chk("R4", "sel 1 ticks in 64", int'(W'(count - c0)), 8);
      wr_cfg(mk(0, 2, 0, 0, 0, 0, 0, 0, 0));
      do_sw(); cyc(3); c0 = count; cyc(128);
      chk("R4", "sel 2 ticks in 128", int'(W'(count - c0)), 4);
      wr_cfg(mk(0, 3, 0, 0, 0, 0, 0, 0, 0));
      do_sw(); cyc(3); c0 = count; cyc(256);
      chk("R4", "sel 3 ticks in 256", int'(W'(count - c0)), 2);
      wr_cfg(mk(0, 4, 0, 0, 0, 0, 0, 0, 0));
      do_sw();
      for (int k = 0; k < 3; k++) begin
         @(negedge clk); slow = 1; @(negedge clk); slow = 0;
      end
      cyc(2);
      chk("R4", "slow clock ticks", count, 3);
      wr_cfg(mk(0, 7, 0, 0, 0, 0, 0, 0, 0));
      do_sw();
      for (int k = 0; k < 2; k++) begin
         @(negedge clk); ext[2] = 1; @(negedge clk); ext[2] = 0;
      end
      cyc(2);
      chk("R4", "ext 2 clock ticks", count, 2);
   endtask

   task automatic t_invert();
      wr_cfg(mk(0, 5, 1, 0, 0, 0, 0, 0, 0));
      do_sw();
      @(negedge clk); ext[0] = 1; cyc(2);
      chk("R5", "no tick on rising", count, 0);
      ext[0] = 0; cyc(2);
      chk("R5", "tick on falling", count, 1);
   endtask

   task automatic t_gate();
      wr_cfg(mk(0, 5, 0, 2, 0, 0, 0, 0, 0));
      ext[1] = 0;
      do_sw();
      tick0(3);
      chk("R6", "gated off", count, 0);
      ext[1] = 1;
      tick0(3);
      chk("R6", "gated on", count, 3);
      ext[1] = 0;
      cyc(2);
   endtask

   task automatic t_halt();
      wr_cfg(mk(0, 5, 0, 0, 1, 0, 0, 0, 0));
      do_sw(); clr();
      tick0(9);
      chk("R8", "held at C", count, 6);
      chk("R8", "halted", active, 0);
      chk("R8", "cmp C once", n_c, 1);
      do_sw();
      chk("R8", "trigger clears", count, 0);
      chk("R8", "trigger resumes", active, 1);
      tick0(2);
      chk("R8", "counting resumed", count, 2);
   endtask

   task automatic t_off();
      wr_cfg(mk(0, 5, 0, 0, 0, 1, 0, 0, 0));
      do_sw();
      tick0(8);
      chk("R9", "held at C", count, 6);
      chk("R9", "switched off", active, 0);
      do_sw();
      chk("R9", "trigger clears", count, 0);
      tick0(2);
      chk("R9", "trigger alone no restart", count, 0);
      do_start();
      chk("R9", "start alone inactive", active, 0);
      do_sw();
      tick0(2);
      chk("R9", "start then trigger restarts", count, 2);
   endtask

   task automatic t_event();
      wr_cfg(mk(0, 5, 0, 0, 0, 0, 2, 1, 1));
      do_sw(); tick0(4); clr();
      @(negedge clk); ext[1] = 1; cyc(2);
      chk("R11", "rising event clears", count, 0);
      chk("R10", "event strobe", n_e, 1);
      chk("R11", "event trigger strobe", n_t, 1);
      ext[1] = 0; cyc(2);
      chk("R10", "falling ignored when rising", n_e, 1);
      tick0(2);
      chk("R11", "counting after event", count, 2);
      wr_cfg(mk(0, 5, 0, 0, 0, 0, 2, 2, 1));
      clr();
      @(negedge clk); ext[1] = 1; cyc(2);
      chk("R10", "rising ignored when falling", count, 2);
      ext[1] = 0; cyc(2);
      chk("R10", "falling event clears", count, 0);
      wr_cfg(mk(0, 5, 0, 0, 0, 0, 2, 3, 0));
      tick0(3); clr();
      @(negedge clk); ext[1] = 1; cyc(2); ext[1] = 0; cyc(2);
      chk("R10", "both edges strobes", n_e, 2);
      chk("R11", "enable clear no effect", count, 3);
      wr_cfg(mk(0, 5, 0, 0, 0, 0, 0, 1, 1));
      @(negedge clk); pinb = 1; cyc(2);
      chk("R10", "pin B event clears", count, 0);
      pinb = 0; cyc(2);
   endtask

   task automatic t_wp();
      wr_cfg(mk(0, 5, 0, 0, 0, 0, 0, 0, 0));
      wp = 1;
      wr_cfg(mk(2, 5, 0, 0, 0, 0, 0, 0, 0));
      wp = 0;
      do_sw(); tick0(8);
      chk("R12", "protected write ignored", count, 8);
      wr_cfg(mk(2, 5, 0, 0, 0, 0, 0, 0, 0));
      do_sw(); tick0(8);
      chk("R12", "unprotected write taken", count, 1);
   endtask

   task automatic t_stop();
      wr_cfg(mk(0, 5, 0, 0, 0, 0, 0, 0, 0));
      do_sw(); tick0(2);
      do_stop();
      chk("R13", "stop halts", active, 0);
      tick0(2);
      chk("R13", "no ticks while stopped", count, 2);
      do_start();
      tick0(1);
      chk("R13", "start resumes", count, 3);
   endtask

   initial begin
      cyc(3);
      rst_n = 1;
      cyc(2);
      t_reset();
      t_up();
      t_auto();
      t_updn();
      t_clk_sel();
      t_invert();
      t_gate();
      t_halt();
      t_off();
      t_event();
      t_wp();
      t_stop();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule